// File: doc/BRIEF.md
# Fixed-point MLP inference engine

This block scores one window of preprocessed pixel data with a fully connected perceptron that has an input layer, a hidden layer and an output layer. Each window pixel contributes two bytes, so a window of `PIX` pixels has `K = 2*PIX` inputs. The bytes arrive on a simple valid/ready stream and are written into one of two window banks. While the engine works on one bank, the next window fills the other.

A single multiplier and accumulator handle one product per clock. The engine first walks every hidden node over all inputs, then every output node over the activated hidden values. Signed 12-bit weights come from an internal ROM whose contents are computed at elaboration. A 256-entry table of signed 8-bit tanh-like values supplies the activation. The engine flags the first multiply cycle of a window with `run_start`. It flags the publication of the output scores with a one-cycle `done`.

Top module: `mlp_engine`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `in_ready` is 1, `run_start` and `done` are 0, and `score` is all zeros.
- R2: A byte is taken when `in_valid` and `in_ready` are both high at a rising edge. Each successive group of `K` taken bytes forms one window, where input i is the i-th byte of the group. Windows are scored in arrival order.
- R3: Two banks hold windows. `in_ready` is 0 exactly when both banks hold a complete window that has not yet been released by `done`. Otherwise it is 1, so a window can load while the previous one is being scored.
- R4: Weight address a holds the 12-bit two's-complement value `(a*1237 + 411) mod 4096`. Hidden node j with input i uses address `j*K + i`. Output node m with hidden node j uses address `K*H + m*H + j`.
- R5: The activation of an accumulated sum s is computed in three steps. First, x = s arithmetically shifted right by 14. Second, x is clamped to [-128, 127]. Third, the result is `(127*x)/(|x|+32)`, with the division truncated toward zero.
- R6: All hidden nodes are finished before any output node starts. Hidden node j is act(sum over i of x_i*w), where each x_i is an unsigned byte. Output m is act(sum over j of h_j*w). Output m appears as a signed byte on `score[8m+7:8m]`.
- R7: `run_start` and `done` are single-cycle pulses. `done` is high exactly `K*H + H*M` cycles after the cycle in which `run_start` was high.
- R8: `score` changes only in a cycle where `done` is high, and it holds its value until the next `done`.
- R9: If a complete window is waiting in the other bank when `done` is high, `run_start` is high in the very next cycle.
- R10: Bytes presented while `in_ready` is 0 are ignored and leave no trace in any later score.
- R11: The accumulator never wraps, including the case where every input is 255. Saturation happens only in the clamp step of R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte present |
| in_data | input | 8 | Input byte (unsigned) |
| in_ready | output | 1 | A bank has room for the byte |
| run_start | output | 1 | First multiply cycle of a window |
| done | output | 1 | Scores published this cycle |
| score | output | 8*OUTN | Signed 8-bit score per output node |

## Verification
Two events can land on the same clock edge. One is the last byte of a window landing in the filling bank. The other is the engine releasing the other bank when it raises `done`. When both happen together, the bank state seen in the following idle cycle must already show the new window as complete. The bench provokes this alignment with random idle gaps between bytes and with back-to-back loads that hold the stream against a full pair of banks. It judges the outcome in three ways: `run_start` must follow `done` by exactly one cycle whenever a full window was waiting, `in_ready` must track the count of unreleased complete windows, and every score must match the window that was actually accepted.

// File: rtl/mlp_pkg.sv
package mlp_pkg;

    localparam int PIX_W = 8;
    localparam int WGT_W = 12;
    localparam int ACT_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HID  = 2'd1,
        ST_OUT  = 2'd2
    } eng_state_e;

    // operands of the single multiply-accumulate
    typedef struct packed {
        logic signed [PIX_W:0]   opnd;
        logic signed [WGT_W-1:0] wgt;
    } mac_in_t;

    function automatic int max2(int a, int b);
        return (a > b) ? a : b;
    endfunction

    // weight stored at one ROM address
    function automatic logic signed [WGT_W-1:0] weight_fn(int addr, int mul, int add);
        int raw;
        raw = (addr * mul + add) % (1 << WGT_W);
        return WGT_W'(raw);
    endfunction

    // tanh-like squashing curve for one table slot
    function automatic logic signed [ACT_W-1:0] squash_fn(int x);
        int mag;
        mag = (x < 0) ? -x : x;
        return ACT_W'((127 * x) / (mag + 32));
    endfunction

endpackage

// File: rtl/mlp_inbuf.sv
module mlp_inbuf
    import mlp_pkg::*;
#(
    parameter int K     = 8,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [PIX_W-1:0] in_data,
    output logic             in_ready,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [PIX_W-1:0] rd_data,
    output logic             bank_ready,
    input  logic             release_i
);

    logic [PIX_W-1:0] bank_q [2][K];
    logic [1:0]       full_q;
    logic             fill_bank_q;
    logic             run_bank_q;
    logic [IDX_W-1:0] fill_idx_q;
    logic             wr_en;
    logic             fill_last;

    assign in_ready   = !full_q[fill_bank_q];
    assign wr_en      = in_valid && in_ready;
    assign fill_last  = (fill_idx_q == IDX_W'(K - 1));
    assign bank_ready = full_q[run_bank_q];
    assign rd_data    = bank_q[run_bank_q][rd_idx];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            bank_q[fill_bank_q][fill_idx_q] <= in_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            full_q      <= '0;
            fill_bank_q <= 1'b0;
            run_bank_q  <= 1'b0;
            fill_idx_q  <= '0;
        end else begin
            if (wr_en) begin
                if (fill_last) begin
                    full_q[fill_bank_q] <= 1'b1;
                    fill_bank_q         <= ~fill_bank_q;
                    fill_idx_q          <= '0;
                end else begin
                    fill_idx_q <= fill_idx_q + 1'b1;
                end
            end
            if (release_i) begin
                full_q[run_bank_q] <= 1'b0;
                run_bank_q         <= ~run_bank_q;
            end
        end
    end

    // R3
    release_full_chk: assert property (@(posedge clk) disable iff (rst)
        release_i |-> full_q[run_bank_q]);

    // R2
    bank_swap_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && fill_last) |=> (fill_bank_q != $past(fill_bank_q)));

endmodule

// File: rtl/mlp_weight_rom.sv
module mlp_weight_rom
    import mlp_pkg::*;
#(
    parameter int DEPTH  = 40,
    parameter int ADDR_W = 6,
    parameter int WMUL   = 1237,
    parameter int WADD   = 411
) (
    input  logic [ADDR_W-1:0]       addr_i,
    output logic signed [WGT_W-1:0] wgt_o
);

    logic signed [WGT_W-1:0] rom [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_rom
        assign rom[g] = weight_fn(g, WMUL, WADD);
    end

    assign wgt_o = rom[addr_i];

endmodule

// File: rtl/mlp_act_lut.sv
module mlp_act_lut
    import mlp_pkg::*;
#(
    parameter int ACC_W = 25,
    parameter int SHIFT = 14
) (
    input  logic signed [ACC_W-1:0] sum_i,
    output logic signed [ACT_W-1:0] act_o
);

    localparam int LUT_N = 1 << ACT_W;
    localparam logic signed [ACC_W-1:0] SAT_HI = ACC_W'((1 << (ACT_W - 1)) - 1);
    localparam logic signed [ACC_W-1:0] SAT_LO = ACC_W'(-(1 << (ACT_W - 1)));

    logic signed [ACT_W-1:0] lut [LUT_N];
    logic signed [ACC_W-1:0] shifted;
    logic signed [ACT_W-1:0] idx_s;

    for (genvar g = 0; g < LUT_N; g++) begin : g_lut
        assign lut[g] = squash_fn(g - LUT_N / 2);
    end

    assign shifted = sum_i >>> SHIFT;

    always_comb begin
        if (shifted > SAT_HI) begin
            idx_s = SAT_HI[ACT_W-1:0];
        end else if (shifted < SAT_LO) begin
            idx_s = SAT_LO[ACT_W-1:0];
        end else begin
            idx_s = shifted[ACT_W-1:0];
        end
    end

    // offset-binary table address: flip the sign bit
    assign act_o = lut[{~idx_s[ACT_W-1], idx_s[ACT_W-2:0]}];

endmodule

// File: rtl/mlp_mac_core.sv
module mlp_mac_core
    import mlp_pkg::*;
#(
    parameter int K      = 8,
    parameter int H      = 4,
    parameter int M      = 2,
    parameter int ACC_W  = 25,
    parameter int ADDR_W = 6,
    parameter int IDX_W  = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    buf_ready,
    output logic                    release_o,
    output logic [IDX_W-1:0]        rd_idx_o,
    input  logic [PIX_W-1:0]        rd_data,
    output logic [ADDR_W-1:0]       waddr_o,
    input  logic signed [WGT_W-1:0] wgt_i,
    output logic signed [ACC_W-1:0] mac_sum_o,
    input  logic signed [ACT_W-1:0] act_i,
    output logic                    run_start_o,
    output logic                    done_o,
    output logic [M*ACT_W-1:0]      score_o
);

    localparam int MAX_T  = max2(K, H);
    localparam int TERM_W = $clog2(MAX_T);
    localparam int NODE_W = $clog2(max2(H, M));
    localparam int HID_IW = $clog2(H);

    eng_state_e              state_q;
    logic [TERM_W-1:0]       term_q;
    logic [NODE_W-1:0]       node_q;
    logic [ADDR_W-1:0]       waddr_q;
    logic signed [ACC_W-1:0] acc_q;
    logic signed [ACT_W-1:0] hid_q [H];
    logic [M*ACT_W-1:0]      out_q;
    logic [M*ACT_W-1:0]      out_next;
    logic [M*ACT_W-1:0]      score_q;
    logic                    run_start_q;
    logic                    done_q;

    mac_in_t                 op;
    logic signed [ACC_W-1:0] prod;
    logic                    term_last;
    logic                    node_last;
    logic [HID_IW-1:0]       hidx;

    assign hidx     = term_q[HID_IW-1:0];
    assign rd_idx_o = term_q[IDX_W-1:0];
    assign waddr_o  = waddr_q;

    // operand select: unsigned input byte or signed hidden activation
    always_comb begin
        if (state_q == ST_HID) begin
            op.opnd = {1'b0, rd_data};
        end else begin
            op.opnd = {hid_q[hidx][ACT_W-1], hid_q[hidx]};
        end
        op.wgt = wgt_i;
    end

    assign prod      = ACC_W'($signed(op.opnd)) * ACC_W'($signed(op.wgt));
    assign mac_sum_o = acc_q + prod;

    always_comb begin
        if (state_q == ST_HID) begin
            term_last = (term_q == TERM_W'(K - 1));
            node_last = (node_q == NODE_W'(H - 1));
        end else begin
            term_last = (term_q == TERM_W'(H - 1));
            node_last = (node_q == NODE_W'(M - 1));
        end
    end

    assign release_o = (state_q == ST_OUT) && term_last && node_last;

    always_comb begin
        for (int m = 0; m < M; m++) begin
            out_next[m*ACT_W +: ACT_W] = (node_q == NODE_W'(m)) ? act_i
                                                                : out_q[m*ACT_W +: ACT_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            term_q      <= '0;
            node_q      <= '0;
            waddr_q     <= '0;
            acc_q       <= '0;
            out_q       <= '0;
            score_q     <= '0;
            run_start_q <= 1'b0;
            done_q      <= 1'b0;
            for (int j = 0; j < H; j++) begin
                hid_q[j] <= '0;
            end
        end else begin
            run_start_q <= 1'b0;
            done_q      <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (buf_ready) begin
                        state_q     <= ST_HID;
                        run_start_q <= 1'b1;
                        term_q      <= '0;
                        node_q      <= '0;
                        waddr_q     <= '0;
                        acc_q       <= '0;
                    end
                end
                ST_HID, ST_OUT: begin
                    waddr_q <= waddr_q + 1'b1;
                    if (term_last) begin
                        acc_q  <= '0;
                        term_q <= '0;
                        if (state_q == ST_HID) begin
                            hid_q[node_q[HID_IW-1:0]] <= act_i;
                        end else begin
                            out_q <= out_next;
                        end
                        if (node_last) begin
                            node_q <= '0;
                            if (state_q == ST_HID) begin
                                state_q <= ST_OUT;
                            end else begin
                                state_q <= ST_IDLE;
                                done_q  <= 1'b1;
                                score_q <= out_next;
                            end
                        end else begin
                            node_q <= node_q + 1'b1;
                        end
                    end else begin
                        acc_q  <= mac_sum_o;
                        term_q <= term_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign run_start_o = run_start_q;
    assign done_o      = done_q;
    assign score_o     = score_q;

    // R6
    hid_before_out_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_OUT) |-> ($past(state_q) != ST_IDLE));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    // R7
    start_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(run_start_q && done_q));

    // R8
    score_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done_q |-> $stable(score_q));

endmodule

// File: rtl/mlp_engine.sv
module mlp_engine
    import mlp_pkg::*;
#(
    parameter int PIX   = 4,
    parameter int HID   = 4,
    parameter int OUTN  = 2,
    parameter int SHIFT = 14,
    parameter int WMUL  = 1237,
    parameter int WADD  = 411
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic [7:0]            in_data,
    output logic                  in_ready,
    output logic                  run_start,
    output logic                  done,
    output logic [OUTN*8-1:0]     score
);

    localparam int K         = 2 * PIX;
    localparam int MAX_T     = max2(K, HID);
    localparam int ACC_W     = PIX_W + 1 + WGT_W + $clog2(MAX_T) + 1;
    localparam int ROM_DEPTH = K * HID + HID * OUTN;
    localparam int ADDR_W    = $clog2(ROM_DEPTH);
    localparam int IDX_W     = $clog2(K);

    logic                    bank_ready;
    logic                    release_w;
    logic [IDX_W-1:0]        rd_idx;
    logic [PIX_W-1:0]        rd_data;
    logic [ADDR_W-1:0]       waddr;
    logic signed [WGT_W-1:0] wgt;
    logic signed [ACC_W-1:0] mac_sum;
    logic signed [ACT_W-1:0] act;

    mlp_inbuf #(.K(K), .IDX_W(IDX_W)) u_inbuf (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .in_ready   (in_ready),
        .rd_idx     (rd_idx),
        .rd_data    (rd_data),
        .bank_ready (bank_ready),
        .release_i  (release_w)
    );

    mlp_weight_rom #(
        .DEPTH  (ROM_DEPTH),
        .ADDR_W (ADDR_W),
        .WMUL   (WMUL),
        .WADD   (WADD)
    ) u_rom (
        .addr_i (waddr),
        .wgt_o  (wgt)
    );

    mlp_act_lut #(.ACC_W(ACC_W), .SHIFT(SHIFT)) u_lut (
        .sum_i (mac_sum),
        .act_o (act)
    );

    mlp_mac_core #(
        .K      (K),
        .H      (HID),
        .M      (OUTN),
        .ACC_W  (ACC_W),
        .ADDR_W (ADDR_W),
        .IDX_W  (IDX_W)
    ) u_core (
        .clk         (clk),
        .rst         (rst),
        .buf_ready   (bank_ready),
        .release_o   (release_w),
        .rd_idx_o    (rd_idx),
        .rd_data     (rd_data),
        .waddr_o     (waddr),
        .wgt_i       (wgt),
        .mac_sum_o   (mac_sum),
        .act_i       (act),
        .run_start_o (run_start),
        .done_o      (done),
        .score_o     (score)
    );

endmodule

// File: tb/mlp_engine_tb.sv
`timescale 1ns/1ps
module mlp_engine_tb;

    localparam int PIX  = 4;
    localparam int HID  = 4;
    localparam int OUTN = 2;
    localparam int K    = 2 * PIX;
    localparam int LAT  = K * HID + HID * OUTN;
    localparam int NW   = 40;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             in_valid = 1'b0;
    logic [7:0]       in_data = '0;
    logic             in_ready;
    logic             run_start;
    logic             done;
    logic [OUTN*8-1:0] score;

    int checks = 0;
    int errors = 0;
    int win [NW][K];
    int expv [NW][OUTN];
    int done_cnt = 0;
    int landed = 0;
    int cyc = 0;
    int start_cyc = 0;
    int garbage = 0;
    bit mon_on = 0;
    bit exp_start = 0;
    bit prev_rs = 0;
    bit prev_done = 0;
    bit wd_fail = 0;
    logic [OUTN*8-1:0] last_score = '0;

    always #10 clk = ~clk;

    mlp_engine u_dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_ready  (in_ready),
        .run_start (run_start),
        .done      (done),
        .score     (score)
    );

    function automatic int bw(int a);
        int v;
        v = (a * 1237 + 411) % 4096;
        if (v >= 2048) v -= 4096;
        return v;
    endfunction

    function automatic int bact(longint s);
        longint x;
        longint mag;
        x = s >>> 14;
        if (x > 127) x = 127;
        if (x < -128) x = -128;
        mag = (x < 0) ? -x : x;
        return int'((127 * x) / (mag + 32));
    endfunction

    task automatic check(bit ok, string req, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // monitor: all sampling at the falling edge
    always @(negedge clk) begin
        if (mon_on) begin
            cyc++;
            if (cyc > 50000 && !wd_fail) begin
                wd_fail = 1;
                check(0, "watchdog", cyc, 50000);
            end
            if (exp_start) begin
                // R9 next window starts the cycle after done
                check(run_start == 1'b1, "R9 back-to-back start", run_start, 1);
                exp_start = 0;
            end
            if (prev_rs) check(run_start == 1'b0, "R7 run_start pulse", run_start, 0);
            if (prev_done) check(done == 1'b0, "R7 done pulse", done, 0);
            if (run_start) start_cyc = cyc;
            if (done) begin
                check(cyc - start_cyc == LAT, "R7 latency", cyc - start_cyc, LAT);
                for (int m = 0; m < OUTN; m++) begin
                    int got;
                    got = int'($signed(score[m*8 +: 8]));
                    if (done_cnt == 1)
                        check(got == expv[done_cnt][m], "R11 saturating window score", got, expv[done_cnt][m]);
                    else
                        check(got == expv[done_cnt][m], "R2 R4 R5 R6 R10 score", got, expv[done_cnt][m]);
                end
                last_score = score;
                done_cnt++;
                if (landed / K >= done_cnt + 1) exp_start = 1;
            end else begin
                check(score == last_score, "R8 score hold", score, last_score);
            end
            // R3 ready tracks unreleased complete windows
            check(in_ready == ((landed / K - done_cnt) < 2), "R3 in_ready",
                  in_ready, ((landed / K - done_cnt) < 2));
            prev_rs = run_start;
            prev_done = done;
            if (in_valid && in_ready) landed++;
        end
    end

    task automatic send_all();
        for (int w = 0; w < NW; w++) begin
            if (w % 7 == 6) begin
                @(posedge clk); #2; in_valid = 1'b0;
                repeat (60) @(posedge clk);
            end
            for (int i = 0; i < K; i++) begin
                int gap;
                gap = (w % 4 == 0) ? 0 : int'($urandom % 3);
                for (int g = 0; g < gap; g++) begin
                    @(posedge clk); #2; in_valid = 1'b0;
                end
                forever begin
                    @(posedge clk); #2;
                    if (in_ready) begin
                        in_valid = 1'b1;
                        in_data  = 8'(win[w][i]);
                        break;
                    end else begin
                        // R10 junk while full: must be ignored
                        in_valid = 1'b1;
                        in_data  = 8'($urandom);
                        garbage++;
                    end
                end
            end
        end
        @(posedge clk); #2; in_valid = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd20250));
        for (int w = 0; w < NW; w++) begin
            for (int i = 0; i < K; i++) begin
                case (w)
                    0: win[w][i] = 0;
                    1: win[w][i] = 255;
                    2: win[w][i] = (i % 2) ? 255 : 0;
                    3: win[w][i] = i * 32;
                    default: win[w][i] = int'($urandom % 256);
                endcase
            end
        end
        for (int w = 0; w < NW; w++) begin
            int h [HID];
            for (int j = 0; j < HID; j++) begin
                longint s;
                s = 0;
                for (int i = 0; i < K; i++) s += longint'(win[w][i]) * bw(j * K + i);
                h[j] = bact(s);
            end
            for (int m = 0; m < OUTN; m++) begin
                longint s;
                s = 0;
                for (int j = 0; j < HID; j++) s += longint'(h[j]) * bw(K * HID + m * HID + j);
                expv[w][m] = bact(s);
            end
        end

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 values during reset
        check(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
        check(done == 1'b0, "R1 done", done, 0);
        check(run_start == 1'b0, "R1 run_start", run_start, 0);
        check(score == '0, "R1 score", score, 0);
        rst = 1'b0;
        @(negedge clk);
        check(done == 1'b0 && run_start == 1'b0, "R1 after release", {done, run_start}, 0);
        mon_on = 1;

        send_all();
        wait (done_cnt == NW || wd_fail);
        repeat (3) @(negedge clk);
        check(garbage > 0, "R10 junk bytes driven", garbage, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule